// File: doc/BRIEF.md
# Gated Prescaled Down-Counter Timer

This block is a 16-bit down-counting timer core. Its count clock comes from one of two sources: an external timer input pin, or a toggle flop that runs at half the system clock rate. Either source can drive the counter directly. It can also pass through an 8-bit free-running prescaler, with a control field choosing one prescaler bit as the counter clock. A run-enable bit starts and stops counting. An optional active-low gate input can pause the prescaler and the counter while they are enabled.

Each time the counter passes from 1 to 0, it reloads from a preload register and toggles an output pin. The output pin of one instance can feed the timer input of a second instance to build a wider counter. Three status flags record events: counter terminal, gate falling edge, and counter wrap from zero. Software clears a flag by writing 1 to it. A single interrupt line is the OR of every flag that is unmasked. With all masks off, the block works in polling mode.

Counting permission comes from a three-state run controller. The states are HOLD (run enable off), COUNT (advancing) and PAUSE (enabled but the gate is closed). The transitions are:
- start: HOLD to COUNT.
- stall: HOLD to PAUSE.
- gate close: COUNT to PAUSE.
- gate open: PAUSE to COUNT.
- stop: any state to HOLD, taken when run enable falls.

Top module: `gated_down_timer`

## Requirements
- R1: After reset, `sts_flags` is 000, `tmr_out` is 0 and `irq` is 0.
- R2: Control word layout: bits 2:0 are interrupt masks, bit 3 is gate enable, bit 4 is prescale select, bit 5 is run enable, bit 6 is clock source (0 = half system clock) and bits 9:7 are the prescaler tap. The control word is written with `ctl_sel`=0. With `ctl_sel`=1, the write sets both the preload register and the counter. With the half-rate source and no prescaling, and preload N≥2, `tmr_out` toggles every 2·N system clocks, because the counter reloads from preload when it passes from 1 to 0.
- R3: With prescale select bit 4 = 1 and tap k, the counter advances on each rising edge of prescaler bit k. With the half-rate source, `tmr_out` therefore toggles every N·2^(k+2) clocks.
- R4: With clock source bit 6 = 1, the counter or prescaler advances once per rising edge of the synchronized `tmr_in`. An input period of P≥4 clocks gives a toggle every N·P clocks without prescaling, and every N·2P clocks with tap 0.
- R5: While run enable bit 5 is 0, the prescaler and the counter hold, and `tmr_out` does not change.
- R6: When gate enable bit 3 is 1 and `gate_n` is high, counting halts. Driving `gate_n` low resumes it. When bit 3 is 0, `gate_n` has no effect on counting.
- R7: A falling edge on the synchronized `gate_n` sets `sts_flags[1]` when gate enable is 1. When gate enable is 0, a falling edge leaves the flag unchanged.
- R8: Each terminal event (counter passing from 1 to 0) sets `sts_flags[0]`.
- R9: A tick at count 0 wraps the counter to all ones and sets `sts_flags[2]`.
- R10: `irq` = OR over i of (`sts_flags[i]` AND mask bit i). Mask bit 2 is for wrap, bit 1 is for gate and bit 0 is for terminal. A mask of 000 keeps `irq` at 0 whatever the flags hold.
- R11: Writing 1 to a bit of `sts_clr_mask` with `sts_clr_we` clears that flag. If a set event arrives in the same cycle as a clear, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_sel | input | 1 | 0 = control word, 1 = preload (also loads counter) |
| ctl_wdata | input | CNT_W | Write data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-1-to-clear mask for the flags |
| sts_flags | output | 3 | {wrap, gate edge, terminal} flags |
| tmr_in | input | 1 | External count clock, asynchronous |
| gate_n | input | 1 | Active-low gate, asynchronous |
| tmr_out | output | 1 | Toggles on each terminal event |
| irq | output | 1 | Interrupt request |

## Verification
A gate falling edge can set the gate flag in the same cycle that software writes 1 to clear it. The bench lowers `gate_n` right after a clock edge. The synchronizer and the edge detector then make the set land exactly three edges later. The clear strobe is held across that third edge only. The flag must read 1 afterwards, and a later clear on its own must bring it to 0. Terminal intervals are judged by a scoreboard that stores the expected toggle spacing for each clock configuration and compares each spacing the monitor measures on `tmr_out`.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

    localparam int PRE_W  = 8;
    localparam int TAP_W  = $clog2(PRE_W);
    localparam int NFLAG  = 3;

    localparam int FLG_TERM = 0;
    localparam int FLG_GATE = 1;
    localparam int FLG_WRAP = 2;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PAUSE = 2'd2
    } run_state_e;

    // packed msb first: tap[9:7], src[6], run[5], pre_sel[4], gate_en[3], mask[2:0]
    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             src_ext;
        logic             run_en;
        logic             pre_sel;
        logic             gate_en;
        logic [NFLAG-1:0] mask;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {(STAGES*W){RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gdt_runctl.sv
module gdt_runctl
    import gdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic gate_en,
    input  logic gate_n_s,
    output logic run,
    output logic gate_fall
);
    run_state_e st, st_nx;
    logic       blocked;
    logic       gate_q;

    assign blocked = gate_en & gate_n_s;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HOLD: begin
                if (run_en && blocked)       st_nx = ST_PAUSE;
                else if (run_en)             st_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run_en)                 st_nx = ST_HOLD;
                else if (blocked)            st_nx = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!run_en)                 st_nx = ST_HOLD;
                else if (!blocked)           st_nx = ST_COUNT;
            end
            default:                         st_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= st_nx;
    end

    always_comb begin
        run = (st == ST_COUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_n_s;
    end

    assign gate_fall = gate_en & gate_q & ~gate_n_s;

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !run);

    // R6
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && gate_n_s) |=> !run);
endmodule

// File: rtl/gdt_clkgen.sv
module gdt_clkgen
    import gdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_ext,
    input  logic             pre_sel,
    input  logic [TAP_W-1:0] tap,
    input  logic             tin_s,
    output logic             ctr_tick
);
    logic             div2;
    logic             gclk_q;
    logic             tap_q;
    logic [PRE_W-1:0] pre;
    logic             sel_clk, gclk, clk_edge, tap_bit, tap_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div2 <= 1'b0;
        else        div2 <= ~div2;
    end

    assign sel_clk  = src_ext ? tin_s : div2;
    // a disabled clock is forced high so no rising edge can appear
    assign gclk     = sel_clk | ~run;
    assign clk_edge = run & gclk & ~gclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gclk_q <= 1'b1;
            pre    <= '0;
            tap_q  <= 1'b0;
        end else begin
            gclk_q <= gclk;
            if (clk_edge) pre <= pre - 1'b1;
            tap_q  <= tap_bit;
        end
    end

    assign tap_bit  = pre[tap];
    assign tap_edge = run & tap_bit & ~tap_q;
    assign ctr_tick = pre_sel ? tap_edge : clk_edge;

    // R5
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pre));
endmodule

// File: rtl/gdt_counter.sv
module gdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             tc_evt,
    output logic             wrap_evt,
    output logic             tout
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] preload;

    assign tc_evt   = tick & ~load & (cnt == CNT_ONE);
    assign wrap_evt = tick & ~load & (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            preload <= '0;
            tout    <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            preload <= load_val;
        end else if (tick) begin
            if (cnt == CNT_ONE) begin
                cnt  <= preload;
                tout <= ~tout;
            end else begin
                cnt  <= cnt - 1'b1;
            end
        end
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> (cnt == $past(preload)));

    // R8
    tout_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> (tout != $past(tout)));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (cnt == {CNT_W{1'b1}}));
endmodule

// File: rtl/gdt_flags.sv
module gdt_flags
    import gdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_mask,
    input  logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            logic f_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) f_q <= 1'b0;
                else        f_q <= set[i] | (f_q & ~(clr_we & clr_mask[i]));
            end
            assign flags[i] = f_q;

            // R11
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> f_q);

            // R11
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_mask[i] && !set[i]) |=> !f_q);
        end
    endgenerate

    assign irq = |(flags & mask);

    // R10
    polling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/gated_down_timer.sv
module gated_down_timer
    import gdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_sel,
    input  logic [CNT_W-1:0] ctl_wdata,
    input  logic             sts_clr_we,
    input  logic [NFLAG-1:0] sts_clr_mask,
    output logic [NFLAG-1:0] sts_flags,
    input  logic             tmr_in,
    input  logic             gate_n,
    output logic             tmr_out,
    output logic             irq
);
    ctrl_t            ctrl;
    logic             tin_s, gate_n_s;
    logic             run, gate_fall, ctr_tick;
    logic             tc_evt, wrap_evt;
    logic             load;
    logic [NFLAG-1:0] set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ctrl <= '0;
        else if (ctl_we && !ctl_sel) ctrl <= ctrl_t'(ctl_wdata[CTRL_W-1:0]);
    end

    assign load = ctl_we & ctl_sel;

    gdt_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_tin (
        .clk(clk), .rst_n(rst_n), .d(tmr_in), .q(tin_s)
    );

    gdt_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_gate (
        .clk(clk), .rst_n(rst_n), .d(gate_n), .q(gate_n_s)
    );

    gdt_runctl u_runctl (
        .clk(clk), .rst_n(rst_n),
        .run_en(ctrl.run_en), .gate_en(ctrl.gate_en), .gate_n_s(gate_n_s),
        .run(run), .gate_fall(gate_fall)
    );

    gdt_clkgen u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run),
        .src_ext(ctrl.src_ext), .pre_sel(ctrl.pre_sel), .tap(ctrl.tap),
        .tin_s(tin_s), .ctr_tick(ctr_tick)
    );

    gdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_val(ctl_wdata), .tick(ctr_tick),
        .tc_evt(tc_evt), .wrap_evt(wrap_evt), .tout(tmr_out)
    );

    always_comb begin
        set           = '0;
        set[FLG_TERM] = tc_evt;
        set[FLG_GATE] = gate_fall;
        set[FLG_WRAP] = wrap_evt;
    end

    gdt_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set(set), .clr_we(sts_clr_we), .clr_mask(sts_clr_mask),
        .mask(ctrl.mask), .flags(sts_flags), .irq(irq)
    );
endmodule

// File: tb/gated_down_timer_bench.sv
module gated_down_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int EXT_P      = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, ctl_sel = 1'b0;
    logic [CW-1:0] ctl_wdata = '0;
    logic          sts_clr_we = 1'b0;
    logic [2:0]    sts_clr_mask = '0;
    logic [2:0]    sts_flags;
    logic          tmr_in = 1'b0, gate_n = 1'b1;
    logic          tmr_out, irq;

    gated_down_timer #(.CNT_W(CW)) u_gated_down_timer (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .sts_flags(sts_flags), .tmr_in(tmr_in), .gate_n(gate_n),
        .tmr_out(tmr_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int val; string tag; } exp_t;
    exp_t exp_q[$];
    int   errors = 0, checks = 0, cyc = 0, stamp = 0, toggles = 0;
    bit   resync = 1'b1, ext_on = 1'b0;
    logic tout_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measure spacing of tmr_out toggles and score against queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tmr_out !== tout_prev) begin
                toggles++;
                if (resync) begin
                    resync = 1'b0;
                end else if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, cyc - stamp, e.val);
                end
                stamp = cyc;
            end
            tout_prev = tmr_out;
        end
    end

    // external clock generator, period EXT_P cycles
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk); #1;
            if (ext_on) begin
                ph = (ph + 1) % EXT_P;
                tmr_in = (ph < EXT_P/2);
            end else begin
                tmr_in = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog (all requirements): actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int cw(int mask, int gen, int psel, int run, int src, int tap);
        return mask | (gen << 3) | (psel << 4) | (run << 5) | (src << 6) | (tap << 7);
    endfunction

    task automatic wr(input bit sel, input int data);
        @(posedge clk); #1;
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = data[CW-1:0];
        @(posedge clk); #1;
        ctl_we = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        @(posedge clk); #1;
        sts_clr_we = 1'b1; sts_clr_mask = m;
        @(posedge clk); #1;
        sts_clr_we = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // driver: push expected spacings, start the timer, then require the queue drained
    task automatic run_sb(input string tag, input int n, input int ctrlw,
                          input int interval, input int count);
        wr(0, 0);
        wr(1, n);
        resync = 1'b1;
        for (int k = 0; k < count; k++) exp_q.push_back('{interval, tag});
        wr(0, ctrlw);
        idle((count + 2) * interval + 40);
        chk({tag, " drained"}, exp_q.size(), 0);
        exp_q.delete();
        wr(0, 0);
    endtask

    initial begin
        int t0;
        idle(4); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 flags", sts_flags, 0);
        chk("R1 tout", tmr_out, 0);
        chk("R1 irq", irq, 0);

        // R2 direct half-rate clock
        run_sb("R2", 5, cw(0,0,0,1,0,0), 10, 3);
        run_sb("R2", 2, cw(0,0,0,1,0,0), 4, 4);
        // R3 prescaler taps
        run_sb("R3", 3, cw(0,0,1,1,0,0), 12, 2);
        run_sb("R3", 2, cw(0,0,1,1,0,2), 32, 2);
        // R4 external source
        ext_on = 1'b1;
        idle(10);
        run_sb("R4", 4, cw(0,0,0,1,1,0), 4*EXT_P, 2);
        run_sb("R4", 2, cw(0,0,1,1,1,0), 2*2*EXT_P, 2);
        ext_on = 1'b0;

        // R5 run enable off holds everything
        wr(1, 3);
        wr(0, cw(0,0,0,0,0,0));
        t0 = toggles;
        idle(100);
        chk("R5 no toggles while stopped", toggles - t0, 0);
        wr(0, cw(0,0,0,1,0,0));
        idle(40);
        chk("R5 toggles after enable", int'(toggles > t0), 1);

        // R6 gate halts when enabled, ignored when not
        wr(0, 0);
        gate_n = 1'b1;
        wr(0, cw(0,1,0,1,0,0));
        t0 = toggles;
        idle(100);
        chk("R6 gate closed halts", toggles - t0, 0);
        @(posedge clk); #1 gate_n = 1'b0;
        idle(60);
        chk("R6 gate open counts", int'(toggles > t0), 1);
        wr(0, 0);
        @(posedge clk); #1 gate_n = 1'b1;
        wr(0, cw(0,0,0,1,0,0));
        t0 = toggles;
        idle(60);
        chk("R6 gate ignored when disabled", int'(toggles > t0), 1);
        wr(0, 0);

        // R7 gate edge with gate enable off: no flag
        clr(3'b111);
        @(posedge clk); #1 gate_n = 1'b0;
        idle(10);
        @(negedge clk);
        chk("R7 no flag when gate disabled", sts_flags[1], 0);
        @(posedge clk); #1 gate_n = 1'b1;
        idle(10);

        // R7 + R11 set and clear in the same cycle
        wr(0, cw(0,1,0,0,0,0));
        idle(5);
        @(posedge clk); #1 gate_n = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        sts_clr_we = 1'b1; sts_clr_mask = 3'b010;
        @(posedge clk); #1;
        sts_clr_we = 1'b0; sts_clr_mask = '0;
        @(negedge clk);
        chk("R7 R11 gate flag set wins over clear", sts_flags[1], 1);
        clr(3'b010);
        @(negedge clk);
        chk("R11 clear gate flag", sts_flags[1], 0);
        @(posedge clk); #1 gate_n = 1'b1;
        wr(0, 0);

        // R8 + R10 polling then unmasked
        clr(3'b111);
        wr(1, 2);
        wr(0, cw(0,0,0,1,0,0));
        idle(30);
        @(negedge clk);
        chk("R8 terminal flag", sts_flags[0], 1);
        chk("R10 polling irq low", irq, 0);
        wr(0, cw(1,0,0,1,0,0));
        @(negedge clk);
        chk("R10 irq on unmasked terminal", irq, 1);
        wr(0, cw(6,0,0,0,0,0));
        @(negedge clk);
        chk("R10 terminal masked", irq, 0);
        clr(3'b001);
        @(negedge clk);
        chk("R11 terminal cleared", sts_flags, 0);

        // R9 wrap from zero
        wr(0, 0);
        wr(1, 0);
        wr(0, cw(4,0,0,1,0,0));
        idle(20);
        @(negedge clk);
        chk("R9 wrap flag", sts_flags[2], 1);
        chk("R9 no terminal after wrap", sts_flags[0], 0);
        chk("R10 irq on wrap", irq, 1);
        wr(0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule